// File: doc/BRIEF.md
# Latched parallel-in serial-out shifter

This block turns a parallel word into a serial bit stream through two storage stages. A holding latch captures the parallel inputs whenever the latch strobe rises. A shift register of the same width either copies that latch or shifts serial data toward its last stage. A level on the mode select picks the behaviour: low copies the latch, high shifts. The last stage drives the serial output. An active-low enable decides whether that output is driven or left floating.

Everything runs on one system clock. Both strobes are ordinary synchronous inputs, and the block acts on a strobe in the cycle where it is seen high after having been seen low. While the mode is low, the shift register copies the latch on every clock. A new latch value therefore reaches the shift register one clock after it is captured. The serial output is given as a data bit plus a drive flag, and the three-state pin is built from those two signals inside the block. Stage A is bit 0 of the shift register and stage H is bit WIDTH-1.

Top module: `piso_latched`

## Requirements
- R1: A synchronous active-high reset clears the holding latch and the shift register to all zeros. After reset is released, a strobe that was already high during reset does not count as a rising edge.
- R2: In a cycle where latch_stb is high and was low in the previous cycle, the holding latch takes par_in. In every other cycle the latch keeps its value.
- R3: With shift_mode high, in a cycle where shift_stb is high and was low in the previous cycle, the register takes {reg[WIDTH-2:0], ser_in}. Stage A (bit 0) takes ser_in, and each stage passes its value to the next stage up. In every other mode-high cycle the register keeps its value.
- R4: ser_data always equals the last stage (bit WIDTH-1) of the shift register.
- R5: With shift_mode low, the shift register takes the latch value at every clock. A latch capture therefore reaches the register one clock later. While the mode is low, ser_in and shift_stb have no effect.
- R6: ser_drive is high exactly when oe_n is low. While ser_drive is high, ser_pin equals ser_data. Otherwise ser_pin is high impedance.
- R7: oe_n has no effect on the latch or on the shift register.
- R8: If both strobes rise in the same cycle with shift_mode high, the shift uses the register's previous contents. The latch captures par_in at the same time, without any effect on that shift.
- R9: A strobe that is held high acts only once, in its first high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | WIDTH | Parallel word to be captured |
| latch_stb | input | 1 | The latch captures par_in on a rising edge of this input |
| ser_in | input | 1 | Serial input into stage A |
| shift_stb | input | 1 | The register shifts on a rising edge of this input |
| shift_mode | input | 1 | 1 = shift, 0 = copy the latch |
| oe_n | input | 1 | Output enable, active low |
| ser_data | output | 1 | Last stage of the shift register |
| ser_drive | output | 1 | High while the serial pin is driven |
| ser_pin | output | 1 | Three-state serial output |

## Verification
The two functions that can fall in the same cycle are a latch capture and a shift. When they do, the shift must use the register's previous contents, and the new latch word must show up only after a later copy in mode low. The bench sets up this case directly, with both strobes rising together in shift mode. Random stimulus also reaches it often, and a cycle model in the bench checks every output after every clock.

// File: rtl/piso_latched.sv
module piso_latched #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] par_in,
  input  logic             latch_stb,
  input  logic             ser_in,
  input  logic             shift_stb,
  input  logic             shift_mode,
  input  logic             oe_n,
  output logic             ser_data,
  output logic             ser_drive,
  output wire              ser_pin
);

  logic [WIDTH-1:0] hold;
  logic [WIDTH-1:0] sreg;
  logic             latch_stb_q;
  logic             shift_stb_q;
  logic             latch_rise;
  logic             shift_rise;

  assign latch_rise = latch_stb & ~latch_stb_q;
  assign shift_rise = shift_stb & ~shift_stb_q;

  always_ff @(posedge clk) begin
    latch_stb_q <= latch_stb;
    shift_stb_q <= shift_stb;
  end

  always_ff @(posedge clk) begin
    if (rst)
      hold <= '0;
    else if (latch_rise)
      hold <= par_in;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sreg <= '0;
    else if (!shift_mode)
      sreg <= hold;
    else if (shift_rise)
      sreg <= {sreg[WIDTH-2:0], ser_in};
  end

  assign ser_data  = sreg[WIDTH-1];
  assign ser_drive = ~oe_n;
  assign ser_pin   = ser_drive ? ser_data : 1'bz;

endmodule

module piso_latched_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             latch_stb,
  input logic             shift_stb,
  input logic             shift_mode,
  input logic             oe_n,
  input logic             ser_data,
  input logic             ser_pin,
  input logic [WIDTH-1:0] hold,
  input logic [WIDTH-1:0] sreg
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> (hold == '0 && sreg == '0));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(latch_stb)) |-> $stable(hold));

  // R3
  shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(shift_mode) && !$past(shift_stb)) |-> $stable(sreg));

  // R5
  copy_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(shift_mode)) |-> (sreg == $past(hold)));

  // R6
  pin_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (ser_pin == ser_data));

endmodule

bind piso_latched piso_latched_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .latch_stb(latch_stb), .shift_stb(shift_stb),
  .shift_mode(shift_mode), .oe_n(oe_n), .ser_data(ser_data), .ser_pin(ser_pin),
  .hold(hold), .sreg(sreg)
);

// File: tb/tb_piso_latched.sv
`timescale 1ns/1ps
module tb_piso_latched;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] par_in;
  logic         latch_stb, ser_in, shift_stb, shift_mode, oe_n;
  logic         ser_data, ser_drive;
  wire          ser_pin;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_hold, m_sreg;
  logic         m_ls, m_ss;

  always #10 clk = ~clk;

  piso_latched #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .par_in(par_in), .latch_stb(latch_stb),
    .ser_in(ser_in), .shift_stb(shift_stb), .shift_mode(shift_mode),
    .oe_n(oe_n), .ser_data(ser_data), .ser_drive(ser_drive), .ser_pin(ser_pin)
  );

  function automatic logic [W-1:0] next_sreg(logic [W-1:0] s, logic [W-1:0] h,
                                             logic md, logic srise, logic si);
    if (!md) return h;
    if (srise) return {s[W-2:0], si};
    return s;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [W-1:0] p, logic ls, logic si, logic ss,
                      logic md, logic oen, string tag);
    logic lrise, srise;
    @(negedge clk);
    rst = 1'b0; par_in = p; latch_stb = ls; ser_in = si;
    shift_stb = ss; shift_mode = md; oe_n = oen;
    lrise = ls & ~m_ls;
    srise = ss & ~m_ss;
    @(posedge clk);
    #1;
    m_sreg = next_sreg(m_sreg, m_hold, md, srise, si);
    if (lrise) m_hold = p;
    m_ls = ls; m_ss = ss;
    chk(tag, ser_data, m_sreg[W-1]);
    chk("R6", ser_drive, ~oen);
    if (!oen) chk("R6", ser_pin, ser_data);
  endtask

  task automatic do_reset(logic ls, logic ss);
    @(negedge clk);
    rst = 1'b1; latch_stb = ls; shift_stb = ss;
    @(posedge clk);
    #1;
    m_hold = '0; m_sreg = '0; m_ls = ls; m_ss = ss;
  endtask

  task automatic drain(logic oen, string tag);
    for (int i = 0; i < W; i++) begin
      step('0, m_ls, 1'b0, 1'b0, 1'b1, oen, tag);
      step('0, m_ls, 1'b0, 1'b1, 1'b1, oen, tag);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_589a));
    rst = 1'b1; par_in = '0; latch_stb = 1'b0; ser_in = 1'b0;
    shift_stb = 1'b0; shift_mode = 1'b1; oe_n = 1'b0;
    m_ls = 1'b0; m_ss = 1'b0; m_hold = '0; m_sreg = '0;

    // R1: reset with strobes held high; they must not fire after release
    do_reset(1'b1, 1'b1);
    chk("R1", ser_data, 1'b0);
    step(8'hff, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
    step(8'hff, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
    drain(1'b0, "R1");

    // R2 and R5: capture a word, copy it in mode low, one clock late
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    step(8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    chk("R5", ser_data, 1'b1);
    // R5: shift strobe and serial input ignored in mode low
    step(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    // R2: no capture without a rising edge
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    chk("R2", ser_data, 1'b1);

    // R3 and R4: shift a known pattern out
    step(8'ha5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    step(8'ha5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    for (int i = 0; i < W; i++) begin
      step('0, 1'b0, i[0], 1'b1, 1'b1, 1'b0, "R3");
      step('0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
    end
    // R9: shift strobe held high shifts only once
    step('0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 3; i++) step('0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    drain(1'b0, "R9");

    // R7: shifting and capturing while disabled, read back when enabled
    step(8'hc3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    step(8'hc3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    step(8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    drain(1'b0, "R7");

    // R8: both strobes rise together in shift mode
    step(8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    step(8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    step(8'hfe, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
    drain(1'b0, "R8");
    step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    chk("R8", ser_data, 1'b1);
    drain(1'b0, "R8");

    // R4, R6, R9: constrained random run
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] p;
      p = W'($urandom);
      step(p, 1'($urandom), 1'($urandom), 1'($urandom),
           ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0), "R4");
      if (i % 997 == 0) do_reset(1'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule